// File: doc/BRIEF.md
# Layered LDPC Iteration and Termination Controller

This block paces a layered LDPC decoder through its schedule. A start pulse captures a configuration: which base graph is in use, how many base-graph rows are active for the chosen code rate, an iteration limit, and whether decoding may stop early. The controller then presents a row index and an iteration index to the message datapath. Each time the datapath finishes a row, it pulses a row-complete input and reports whether that row's parity check is satisfied. The controller moves to the next row, or wraps to row 0 and opens a new iteration.

Parity is judged once per iteration. An iteration passes only if every active row reported satisfied during that iteration. In early mode, decoding ends after the first passing iteration. In either mode, decoding ends when the iteration limit is reached. At the end the block gives a one-cycle done pulse and reports the number of iterations executed and a pass/fail flag. Both results hold until the next start. A start that arrives mid-decode abandons the decode in progress and begins again with the new configuration.

Top module: `ldpc_iter_ctrl`

## Requirements
- R1: The iteration limit is taken as given for values 1 to 63. A requested value of 0, or any value above 63, is replaced by 8.
- R2: The active row count is clamped to 4..46 when graph select is 0 and to 4..42 when graph select is 1. Row indices run from 0 to the clamped count minus 1.
- R3: Out of reset, busy, done, both strobes, the iteration count and the parity flag are all 0. On the cycle after start_i, busy is 1, the row and iteration indices are 0, both strobes are 1, and the iteration count and parity flag are cleared to 0.
- R4: Each row_done_i while busy advances the row index by one and raises row_stb_o for the following cycle. row_done_i has no effect while the block is idle, and a cycle without row_done_i leaves the row index unchanged.
- R5: row_done_i on the last active row, when decoding does not end, sets the row index to 0, increments the iteration index, and raises both row_stb_o and iter_stb_o for the following cycle.
- R6: An iteration passes only if row_ok_i was 1 on every row_done_i of that iteration. A single 0 makes the iteration fail.
- R7: With early_i = 1, decoding ends after the first passing iteration.
- R8: With early_i = 0, decoding always runs exactly the iteration limit, whatever the parity results.
- R9: Decoding ends after the limit-th iteration even if no iteration passed. The parity flag then reports that final iteration as failing (0).
- R10: done_o is a one-cycle pulse in the cycle after the final row_done_i, and busy drops in that same cycle. iter_cnt_o gives the number of iterations executed and parity_ok_o gives whether the last iteration passed (1 = pass). Both hold until the next start.
- R11: A start_i while busy abandons the current decode and restarts from row 0, iteration 0, with the new configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; captures the configuration |
| graph_sel_i | input | 1 | Base graph select (0 or 1) |
| rows_i | input | ROW_W (6) | Requested active row count |
| iter_lim_i | input | LIM_W (8) | Requested iteration limit |
| early_i | input | 1 | 1 = stop on the first passing iteration, 0 = run the full limit |
| row_done_i | input | 1 | The datapath finished the current row |
| row_ok_i | input | 1 | That row's parity check is satisfied (valid with row_done_i) |
| busy_o | output | 1 | Decode in progress |
| row_idx_o | output | ROW_W (6) | Current row index |
| iter_idx_o | output | ITER_W (6) | Current iteration index, counted from 0 |
| row_stb_o | output | 1 | A new row became current |
| iter_stb_o | output | 1 | A new iteration began |
| done_o | output | 1 | One-cycle end-of-decode pulse |
| iter_cnt_o | output | ITER_W (6) | Iterations executed |
| parity_ok_o | output | 1 | The final iteration passed all checks |

## Verification
The hardest case to reach is an iteration that fails because of one row, including the last row. For that row, the pass decision is formed in the same cycle as the wrap or stop, and a row failing partway through an iteration must still override every later satisfied row. The stimulus table places a single failing row at index 0, at a middle row, or at the final row, for a chosen number of leading iterations, and then lets every row pass. This shows whether the controller stops early, runs the full limit, or exits at the limit with a fail. Some frames also insert a stall cycle without row_done_i and restart mid-decode, to show that the row index holds and that the abandoned decode leaves no result behind.

// File: rtl/ldpc_ctrl_pkg.sv
package ldpc_ctrl_pkg;

  // Action taken by the sequencer on the current cycle.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,  // no row completed
    STEP_ROW  = 2'd1,  // move to next row of the same iteration
    STEP_ITER = 2'd2,  // wrap to row 0 of a new iteration
    STEP_STOP = 2'd3   // decoding finished
  } step_e;

endpackage

// File: rtl/ldpc_cfg_sanitize.sv
module ldpc_cfg_sanitize #(
  parameter int ROW_W       = 6,
  parameter int ITER_W      = 6,
  parameter int LIM_W       = 8,
  parameter int MIN_ROWS    = 4,
  parameter int MAX_ROWS_G0 = 46,
  parameter int MAX_ROWS_G1 = 42,
  parameter int ITER_CAP    = 63,
  parameter int ITER_DEF    = 8
) (
  input  logic              graph_i,
  input  logic [ROW_W-1:0]  rows_i,
  input  logic [LIM_W-1:0]  lim_i,
  output logic [ROW_W-1:0]  rows_o,
  output logic [ITER_W-1:0] lim_o
);

  localparam logic [ROW_W-1:0]  RowsLo  = ROW_W'(MIN_ROWS);
  localparam logic [ROW_W-1:0]  RowsHi0 = ROW_W'(MAX_ROWS_G0);
  localparam logic [ROW_W-1:0]  RowsHi1 = ROW_W'(MAX_ROWS_G1);
  localparam logic [LIM_W-1:0]  LimCap  = LIM_W'(ITER_CAP);
  localparam logic [ITER_W-1:0] LimDef  = ITER_W'(ITER_DEF);

  logic [ROW_W-1:0] rows_hi;

  always_comb begin
    rows_hi = graph_i ? RowsHi1 : RowsHi0;
    if (rows_i < RowsLo)       rows_o = RowsLo;
    else if (rows_i > rows_hi) rows_o = rows_hi;
    else                       rows_o = rows_i;
  end

  always_comb begin
    if ((lim_i == '0) || (lim_i > LimCap)) lim_o = LimDef;
    else                                   lim_o = lim_i[ITER_W-1:0];
  end

endmodule

// File: rtl/ldpc_parity_acc.sv
module ldpc_parity_acc
  import ldpc_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  step_e step_i,
  input  logic  row_ok_i,
  output logic  pass_o
);

  logic acc_q;
  logic acc_d;
  logic acc_en;

  // Pass verdict for the row completing now, folded with earlier rows.
  assign pass_o = acc_q & row_ok_i;

  always_comb begin
    acc_en = 1'b0;
    acc_d  = acc_q;
    if (start_i || (step_i == STEP_ITER) || (step_i == STEP_STOP)) begin
      acc_en = 1'b1;
      acc_d  = 1'b1;
    end else if (step_i == STEP_ROW) begin
      acc_en = 1'b1;
      acc_d  = acc_q & row_ok_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= 1'b1;
    else if (acc_en) acc_q <= acc_d;
  end

  // R6: one failing row mid-iteration keeps the iteration failing
  a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && (step_i == STEP_ROW) && !row_ok_i) |=> !acc_q);

  // R6: a fresh iteration starts with a clean verdict
  a_r6_fresh_iter: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i || (step_i == STEP_ITER)) |=> acc_q);

endmodule

// File: rtl/ldpc_layer_seq.sv
module ldpc_layer_seq
  import ldpc_ctrl_pkg::*;
#(
  parameter int ROW_W       = 6,
  parameter int ITER_W      = 6,
  parameter int MIN_ROWS    = 4,
  parameter int MAX_ROWS_G0 = 46
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  rows_i,
  input  logic [ITER_W-1:0] lim_i,
  input  logic              early_i,
  input  logic              row_done_i,
  input  logic              iter_pass_i,
  output step_e             step_o,
  output logic              busy_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [ITER_W-1:0] iter_o,
  output logic              row_stb_o,
  output logic              iter_stb_o,
  output logic              done_o,
  output logic [ITER_W-1:0] cnt_o,
  output logic              pok_o
);

  localparam logic [ROW_W-1:0]  RowOne  = ROW_W'(1);
  localparam logic [ITER_W-1:0] IterOne = ITER_W'(1);

  // configuration captured at start
  logic [ROW_W-1:0]  last_row_q;
  logic [ITER_W-1:0] lim_q;
  logic              early_q;

  // sequencing state
  logic              busy_q,  busy_d;
  logic [ROW_W-1:0]  row_q,   row_d;
  logic [ITER_W-1:0] iter_q,  iter_d;
  logic              rstb_q,  rstb_d;
  logic              istb_q,  istb_d;
  logic              done_q,  done_d;
  logic [ITER_W-1:0] cnt_q,   cnt_d;
  logic              pok_q,   pok_d;
  logic              res_en;

  logic  at_last_row;
  logic  at_last_iter;
  step_e step;

  assign at_last_row  = (row_q == last_row_q);
  assign at_last_iter = (iter_q == (lim_q - IterOne));

  // step decision
  always_comb begin
    if (!busy_q || !row_done_i)                      step = STEP_HOLD;
    else if (!at_last_row)                           step = STEP_ROW;
    else if (at_last_iter || (early_q && iter_pass_i)) step = STEP_STOP;
    else                                             step = STEP_ITER;
  end

  // next-state
  always_comb begin
    busy_d = busy_q;
    row_d  = row_q;
    iter_d = iter_q;
    rstb_d = 1'b0;
    istb_d = 1'b0;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    pok_d  = pok_q;
    res_en = 1'b0;
    if (start_i) begin
      busy_d = 1'b1;
      row_d  = '0;
      iter_d = '0;
      rstb_d = 1'b1;
      istb_d = 1'b1;
      cnt_d  = '0;
      pok_d  = 1'b0;
      res_en = 1'b1;
    end else begin
      unique case (step)
        STEP_ROW: begin
          row_d  = row_q + RowOne;
          rstb_d = 1'b1;
        end
        STEP_ITER: begin
          row_d  = '0;
          iter_d = iter_q + IterOne;
          rstb_d = 1'b1;
          istb_d = 1'b1;
        end
        STEP_STOP: begin
          busy_d = 1'b0;
          done_d = 1'b1;
          cnt_d  = iter_q + IterOne;
          pok_d  = iter_pass_i;
          res_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // configuration registers, enabled by start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_row_q <= ROW_W'(MIN_ROWS - 1);
      lim_q      <= IterOne;
      early_q    <= 1'b0;
    end else if (start_i) begin
      last_row_q <= rows_i - RowOne;
      lim_q      <= lim_i;
      early_q    <= early_i;
    end
  end

  // sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      row_q  <= '0;
      iter_q <= '0;
      rstb_q <= 1'b0;
      istb_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      row_q  <= row_d;
      iter_q <= iter_d;
      rstb_q <= rstb_d;
      istb_q <= istb_d;
      done_q <= done_d;
    end
  end

  // result registers, enabled on start and on stop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pok_q <= 1'b0;
    end else if (res_en) begin
      cnt_q <= cnt_d;
      pok_q <= pok_d;
    end
  end

  assign step_o     = step;
  assign busy_o     = busy_q;
  assign row_o      = row_q;
  assign iter_o     = iter_q;
  assign row_stb_o  = rstb_q;
  assign iter_stb_o = istb_q;
  assign done_o     = done_q;
  assign cnt_o      = cnt_q;
  assign pok_o      = pok_q;

  // R2: row index never passes the last active row
  a_r2_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (row_q <= last_row_q));

  // R2: captured row span stays within the widest legal graph
  a_r2_rows_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((last_row_q >= ROW_W'(MIN_ROWS - 1)) && (last_row_q <= ROW_W'(MAX_ROWS_G0 - 1))));

  // R1: iteration index stays under a nonzero limit
  a_r1_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((lim_q != '0) && (iter_q < lim_q)));

  // R10: done is a single-cycle pulse and coincides with idle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  // R10: results hold while idle with no start
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_i) |=> ($stable(cnt_q) && $stable(pok_q)));

  // R4: idle ignores row completions
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_i) |=> (!rstb_q && !istb_q && !busy_q));

  // R5: a new iteration always opens on row 0 with a row strobe
  a_r5_iter_opens_row0: assert property (@(posedge clk) disable iff (!rst_n)
    istb_q |-> (rstb_q && (row_q == '0)));

  // R8: max mode reports the full limit
  a_r8_max_full: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !early_q) |-> (cnt_q == lim_q));

endmodule

// File: rtl/ldpc_iter_ctrl.sv
module ldpc_iter_ctrl
  import ldpc_ctrl_pkg::*;
#(
  parameter int ROW_W       = 6,
  parameter int ITER_W      = 6,
  parameter int LIM_W       = 8,
  parameter int MIN_ROWS    = 4,
  parameter int MAX_ROWS_G0 = 46,
  parameter int MAX_ROWS_G1 = 42,
  parameter int ITER_CAP    = 63,
  parameter int ITER_DEF    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              graph_sel_i,
  input  logic [ROW_W-1:0]  rows_i,
  input  logic [LIM_W-1:0]  iter_lim_i,
  input  logic              early_i,
  input  logic              row_done_i,
  input  logic              row_ok_i,
  output logic              busy_o,
  output logic [ROW_W-1:0]  row_idx_o,
  output logic [ITER_W-1:0] iter_idx_o,
  output logic              row_stb_o,
  output logic              iter_stb_o,
  output logic              done_o,
  output logic [ITER_W-1:0] iter_cnt_o,
  output logic              parity_ok_o
);

  logic [ROW_W-1:0]  rows_eff;
  logic [ITER_W-1:0] lim_eff;
  logic              iter_pass;
  step_e             step;

  ldpc_cfg_sanitize #(
    .ROW_W       (ROW_W),
    .ITER_W      (ITER_W),
    .LIM_W       (LIM_W),
    .MIN_ROWS    (MIN_ROWS),
    .MAX_ROWS_G0 (MAX_ROWS_G0),
    .MAX_ROWS_G1 (MAX_ROWS_G1),
    .ITER_CAP    (ITER_CAP),
    .ITER_DEF    (ITER_DEF)
  ) u_cfg (
    .graph_i (graph_sel_i),
    .rows_i  (rows_i),
    .lim_i   (iter_lim_i),
    .rows_o  (rows_eff),
    .lim_o   (lim_eff)
  );

  ldpc_layer_seq #(
    .ROW_W       (ROW_W),
    .ITER_W      (ITER_W),
    .MIN_ROWS    (MIN_ROWS),
    .MAX_ROWS_G0 (MAX_ROWS_G0)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rows_i      (rows_eff),
    .lim_i       (lim_eff),
    .early_i     (early_i),
    .row_done_i  (row_done_i),
    .iter_pass_i (iter_pass),
    .step_o      (step),
    .busy_o      (busy_o),
    .row_o       (row_idx_o),
    .iter_o      (iter_idx_o),
    .row_stb_o   (row_stb_o),
    .iter_stb_o  (iter_stb_o),
    .done_o      (done_o),
    .cnt_o       (iter_cnt_o),
    .pok_o       (parity_ok_o)
  );

  ldpc_parity_acc u_par (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .step_i   (step),
    .row_ok_i (row_ok_i),
    .pass_o   (iter_pass)
  );

  // R7: an early-mode stop short of the limit always reports a pass
  a_r7_early_stop_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (iter_cnt_o < lim_eff) && !start_i && !$past(start_i)) |-> parity_ok_o);

  // R11: a start always lands on row 0, iteration 0, busy
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_o && (row_idx_o == '0) && (iter_idx_o == '0) && iter_stb_o));

endmodule

// File: tb/ldpc_iter_ctrl_tb_top.sv
module ldpc_iter_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  typedef struct packed {
    logic       graph;
    logic [7:0] rows;
    logic [7:0] lim;
    logic       early;
    logic [7:0] pass_from;  // first iteration (from 0) in which all rows pass
    logic [7:0] fail_row;   // row that fails before pass_from (>= rows: last row)
    logic       gap;        // insert one stall cycle
    logic [7:0] exp_rows;
    logic [7:0] exp_cnt;
    logic       exp_pok;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd10, 8'd3,   1'b1, 8'd1,  8'd0,  1'b1, 8'd10, 8'd2,  1'b1},
    '{1'b0, 8'd2,  8'd2,   1'b0, 8'd0,  8'd0,  1'b0, 8'd4,  8'd2,  1'b1},
    '{1'b0, 8'd60, 8'd1,   1'b1, 8'd99, 8'd63, 1'b0, 8'd46, 8'd1,  1'b0},
    '{1'b1, 8'd46, 8'd2,   1'b1, 8'd0,  8'd0,  1'b0, 8'd42, 8'd1,  1'b1},
    '{1'b1, 8'd5,  8'd0,   1'b1, 8'd99, 8'd2,  1'b1, 8'd5,  8'd8,  1'b0},
    '{1'b1, 8'd4,  8'd200, 1'b0, 8'd3,  8'd1,  1'b0, 8'd4,  8'd8,  1'b1},
    '{1'b0, 8'd6,  8'd63,  1'b1, 8'd5,  8'd63, 1'b0, 8'd6,  8'd6,  1'b1},
    '{1'b0, 8'd7,  8'd4,   1'b0, 8'd99, 8'd3,  1'b1, 8'd7,  8'd4,  1'b0},
    '{1'b1, 8'd42, 8'd1,   1'b0, 8'd0,  8'd0,  1'b0, 8'd42, 8'd1,  1'b1},
    '{1'b0, 8'd46, 8'd64,  1'b1, 8'd2,  8'd10, 1'b0, 8'd46, 8'd3,  1'b1},
    '{1'b0, 8'd4,  8'd63,  1'b0, 8'd99, 8'd0,  1'b0, 8'd4,  8'd63, 1'b0}
  };

  logic       clk;
  logic       rst_n;
  logic       start_i, graph_sel_i, early_i, row_done_i, row_ok_i;
  logic [5:0] rows_i;
  logic [7:0] iter_lim_i;
  logic       busy_o, row_stb_o, iter_stb_o, done_o, parity_ok_o;
  logic [5:0] row_idx_o, iter_idx_o, iter_cnt_o;

  int errors = 0;
  int checks = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  ldpc_iter_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .graph_sel_i (graph_sel_i),
    .rows_i      (rows_i),
    .iter_lim_i  (iter_lim_i),
    .early_i     (early_i),
    .row_done_i  (row_done_i),
    .row_ok_i    (row_ok_i),
    .busy_o      (busy_o),
    .row_idx_o   (row_idx_o),
    .iter_idx_o  (iter_idx_o),
    .row_stb_o   (row_stb_o),
    .iter_stb_o  (iter_stb_o),
    .done_o      (done_o),
    .iter_cnt_o  (iter_cnt_o),
    .parity_ok_o (parity_ok_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input vec_t v, input string stag);
    int r, it, fr, guard;
    bit gapped;
    string creq;
    @(negedge clk);
    start_i     = 1'b1;
    graph_sel_i = v.graph;
    rows_i      = v.rows[5:0];
    iter_lim_i  = v.lim;
    early_i     = v.early;
    row_done_i  = 1'b0;
    row_ok_i    = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk(stag, "busy after start", busy_o, 1);
    chk(stag, "row idx after start", row_idx_o, 0);
    chk(stag, "iter idx after start", iter_idx_o, 0);
    chk(stag, "row strobe after start", row_stb_o, 1);
    chk(stag, "iter strobe after start", iter_stb_o, 1);
    chk(stag, "count cleared", iter_cnt_o, 0);
    chk(stag, "flag cleared", parity_ok_o, 0);
    r = 0; it = 0; guard = 0; gapped = 1'b0;
    fr = (v.fail_row >= v.exp_rows) ? int'(v.exp_rows) - 1 : int'(v.fail_row);
    while (busy_o && guard < 20000) begin
      guard++;
      chk("R2/R4", "row index", row_idx_o, r);
      chk("R5", "iteration index", iter_idx_o, it);
      if (r == 0 && it > 0) chk("R5", "iter strobe on wrap", iter_stb_o, 1);
      if (v.gap && r == 1 && !gapped) begin
        row_done_i = 1'b0;
        @(negedge clk);
        gapped = 1'b1;
        chk("R4", "row held on stall", row_idx_o, 1);
        chk("R4", "no strobe on stall", row_stb_o, 0);
        continue;
      end
      row_done_i = 1'b1;
      row_ok_i   = (it >= int'(v.pass_from)) || (r != fr);
      @(negedge clk);
      row_done_i = 1'b0;
      r++;
      if (r == int'(v.exp_rows)) begin
        r = 0;
        it++;
      end
    end
    creq = v.early ? "R1/R7/R9" : "R1/R8/R9";
    chk("R10", "done pulse", done_o, 1);
    chk(creq, "iterations run", it, v.exp_cnt);
    chk(creq, "iteration count", iter_cnt_o, v.exp_cnt);
    chk("R6/R10", "parity flag", parity_ok_o, v.exp_pok);
    // idle: row completions must have no effect, results hold
    row_done_i = 1'b1;
    row_ok_i   = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10", "done one cycle", done_o, 0);
      chk("R4", "idle stays idle", busy_o, 0);
      chk("R4", "idle no strobe", row_stb_o, 0);
      chk("R10", "count held", iter_cnt_o, v.exp_cnt);
      chk("R10", "flag held", parity_ok_o, v.exp_pok);
    end
    row_done_i = 1'b0;
    row_ok_i   = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0; graph_sel_i = 1'b0; rows_i = '0; iter_lim_i = '0;
    early_i = 1'b0; row_done_i = 1'b0; row_ok_i = 1'b0;
    repeat (3) @(negedge clk);
    // R3: reset state
    chk("R3", "busy in reset", busy_o, 0);
    chk("R3", "done in reset", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3", "busy after reset", busy_o, 0);
    chk("R3", "done after reset", done_o, 0);
    chk("R3", "row strobe after reset", row_stb_o, 0);
    chk("R3", "iter strobe after reset", iter_stb_o, 0);
    chk("R3", "count after reset", iter_cnt_o, 0);
    chk("R3", "flag after reset", parity_ok_o, 0);

    // R4: row completions before any start are ignored
    row_done_i = 1'b1;
    row_ok_i   = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4", "idle ignores row_done", busy_o, 0);
    chk("R4", "idle ignores row_done strobe", row_stb_o, 0);
    row_done_i = 1'b0;

    for (int i = 0; i < NV; i++) run_frame(VECS[i], "R3");

    // R11: restart in the middle of a decode
    @(negedge clk);
    start_i = 1'b1; graph_sel_i = 1'b0; rows_i = 6'd20; iter_lim_i = 8'd5; early_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    row_done_i = 1'b1; row_ok_i = 1'b0;
    repeat (3) @(negedge clk);
    row_done_i = 1'b0;
    chk("R11", "mid decode row", row_idx_o, 3);
    run_frame(VECS[3], "R11");

    summary();
    $finish;
  end

endmodule